// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is a two-wire bus slave that lets a bus master reach a small register file through an 8-bit pointer that advances on its own. SCL and SDA are oversampled by the system clock, which must run at least 8 times faster than SCL. The slave pulls SDA low through an open-drain style enable. It finds start, repeated start and stop conditions, shifts bytes most significant bit first, and answers only to the 7-bit device address 0x48. That address is the byte 0x90 for a write and 0x91 for a read.

In a write transfer, the first byte after the address byte sets the pointer. Each later byte goes to the register file through a one-cycle parallel write strobe, and the pointer then advances. In a read transfer, the slave sends the register the pointer selects, and the pointer advances only when the master acknowledges. Every stop sends the pointer back to 0x00, so a master can poll register 0x00 with bare read transfers. Registers 0x00 to 0x12 are valid. Writes beyond that range are acknowledged and dropped, and reads beyond it return 0x00. The pointer cannot be read back over the bus.

Top module: `i2c_reg_slave`

## Requirements
- R1: The address byte 0x90 (write) or 0x91 (read) is acknowledged: the slave holds SDA low for the whole high time of the ninth SCL pulse.
- R2: Any other 7-bit address gets no acknowledge. The slave then leaves SDA released and writes no register until the next start.
- R3: In a write transfer, the byte after the address byte loads the pointer and is acknowledged. Each further byte is acknowledged and presented on reg_waddr_o/reg_wdata_o with reg_we_o high for exactly one clock, and the pointer then advances by one.
- R4: In a read transfer, the slave sends the register at the pointer, MSB first. When the master acknowledges (SDA low on the ninth pulse), the pointer advances and the next register follows.
- R5: When the master does not acknowledge (SDA high on the ninth pulse), the slave releases SDA, goes idle and keeps the pointer. A following repeated-start read returns the same register again.
- R6: Any stop condition (SDA rising while SCL is high) returns the slave to idle and sets the pointer to 0x00.
- R7: A repeated start (SDA falling while SCL is high, with no stop before it) is handled exactly like a start, and it keeps the pointer.
- R8: A data byte written while the pointer is above 0x12 is acknowledged but raises no reg_we_o pulse.
- R9: A read while the pointer is above 0x12 returns 0x00. The slave goes on sending bytes for as long as the master keeps acknowledging.
- R10: sda_oe_o changes only while SCL is low, except when a start or stop releases it.
- R11: While reset is held and right after it, sda_oe_o and reg_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | AW (5) | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | AW (5) | Register read address (low pointer bits) |
| reg_rdata_i | input | 8 | Register read data, combinational from reg_raddr_o |

## Verification
A wrong pointer shows at the ports within one byte time. A stale or early increment makes the next read byte come from a neighbouring register. A pointer that was not cleared makes a read after a stop return something other than register 0x00. A wrong state decode shows at the ninth SCL pulse of the same byte, as a missing or extra acknowledge, or as a write strobe where none belongs. A wrong bit count shifts the read data by one bit position within the same byte.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h48,
  parameter int                AW       = 5,
  parameter logic [BYTE_W-1:0] LAST_REG = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam logic [3:0] BITS = 4'(BYTE_W);

  slv_state_e        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] rx, tx, ptr;
  logic              rw, mack, ack_q, tx_en;
  logic              ptr_ok;
  logic [BYTE_W-1:0] tx_byte;

  assign ptr_ok    = (ptr <= LAST_REG);
  assign rd_addr_o = ptr[AW-1:0];
  assign tx_byte   = ptr_ok ? rd_data_i : '0;
  assign sda_oe_o  = ack_q | (tx_en & ~tx[BYTE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '1;
      ptr       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      ack_q     <= 1'b0;
      tx_en     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state <= ST_IDLE;
        ptr   <= '0;
        ack_q <= 1'b0;
        tx_en <= 1'b0;
      end else if (start_i) begin
        state <= ST_ADDR;
        cnt   <= '0;
        ack_q <= 1'b0;
        tx_en <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise_i) begin
              rx  <= {rx[BYTE_W-2:0], sda_s_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == BITS) begin
              if (state == ST_ADDR) begin
                if (rx[BYTE_W-1:1] == DEV_ADDR) begin
                  rw    <= rx[0];
                  ack_q <= 1'b1;
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr   <= rx;
                ack_q <= 1'b1;
                state <= ST_PTR_ACK;
              end else begin
                // out-of-range data is acknowledged but dropped
                if (ptr_ok) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr[AW-1:0];
                  wr_data_o <= rx;
                end
                ack_q <= 1'b1;
                state <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            if (rw) begin
              tx    <= tx_byte;
              tx_en <= 1'b1;
              state <= ST_RDAT;
            end else begin
              state <= ST_PTR;
            end
          end
          ST_PTR_ACK: if (scl_fall_i) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            state <= ST_WDAT;
          end
          ST_WDAT_ACK: if (scl_fall_i) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            ptr   <= ptr + 1'b1;
            state <= ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt == BITS) begin
                tx_en <= 1'b0;
                state <= ST_RDAT_ACK;
              end else begin
                tx <= {tx[BYTE_W-2:0], 1'b1};
              end
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_s_i;
              if (!sda_s_i) ptr <= ptr + 1'b1;  // advance only on master ack
            end else if (scl_fall_i) begin
              if (mack) begin
                tx    <= tx_byte;
                tx_en <= 1'b1;
                cnt   <= '0;
                state <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h48,
  parameter int                AW          = 5,
  parameter logic [BYTE_W-1:0] LAST_REG    = 8'h12,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [AW-1:0]     reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [AW-1:0]     reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic sda_w, rise_w, fall_w, start_w, stop_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  i2c_ptr_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .AW       (AW),
    .LAST_REG (LAST_REG)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .rd_data_i  (reg_rdata_i),
    .rd_addr_o  (reg_raddr_o),
    .wr_en_o    (reg_we_o),
    .wr_addr_o  (reg_waddr_o),
    .wr_data_o  (reg_wdata_o),
    .sda_oe_o   (sda_oe_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int         AW       = 5,
  parameter logic [7:0] LAST_REG = 8'h12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_waddr_o,
  input logic          start_i,
  input logic          stop_i
);
  p_we_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (8'(reg_waddr_o) <= LAST_REG));

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!$past(scl_i) || !sda_oe_o));

  p_stop_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);

  p_start_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_o);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW), .LAST_REG(LAST_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_waddr_o (reg_waddr_o),
  .start_i     (start_w),
  .stop_i      (stop_w)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic       sda_oe, reg_we;
  logic [4:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic       sda_bus;
  logic [7:0] rf [32];
  int         total = 0, bad = 0, we_cnt = 0, oe_hi_chg = 0;
  logic       oe_prev = 1'b0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = ~(m_sda_low | sda_oe);
  assign rdata   = rf[raddr];

  i2c_reg_slave dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_we_o    (reg_we),
    .reg_waddr_o (waddr),
    .reg_wdata_o (wdata),
    .reg_raddr_o (raddr),
    .reg_rdata_i (rdata)
  );

  // bench register file model, preset to 0xEE
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 8'hEE;
    end else if (reg_we) begin
      rf[waddr] <= wdata;
      we_cnt    <= we_cnt + 1;
    end
  end

  // R10 monitor: output enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && m_scl && (sda_oe !== oe_prev) && sda_oe) oe_hi_chg++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_start();
    tick(4); m_sda_low = 1'b0;
    tick(4); m_scl = 1'b1;
    tick(8); m_sda_low = 1'b1;
    tick(8); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    tick(4); m_sda_low = 1'b1;
    tick(4); m_scl = 1'b1;
    tick(8); m_sda_low = 1'b0;
    tick(8);
  endtask

  task automatic bit_out(input logic b);
    tick(4); m_sda_low = ~b;
    tick(4); m_scl = 1'b1;
    tick(8); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(4); m_sda_low = 1'b0;
    tick(4); m_scl = 1'b1;
    tick(4); b = sda_bus;
    tick(4); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 reg_we in reset", reg_we, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R11 sda_oe after reset", sda_oe, 0);
    chk("R11 reg_we after reset", reg_we, 0);
  endtask

  task automatic t_write_burst();
    logic a;
    int   w0 = we_cnt;
    m_start();
    send_byte(8'h90, a); chk("R1 write address ack", a, 1);
    send_byte(8'h02, a); chk("R3 pointer ack", a, 1);
    send_byte(8'h11, a); chk("R3 data ack", a, 1);
    send_byte(8'h22, a); chk("R3 data ack", a, 1);
    send_byte(8'h33, a); chk("R3 data ack", a, 1);
    m_stop();
    chk("R3 reg2", rf[2], 8'h11);
    chk("R3 reg3", rf[3], 8'h22);
    chk("R3 reg4", rf[4], 8'h33);
    chk("R3 strobe count", we_cnt - w0, 3);
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h00, a);
    send_byte(8'h5A, a); chk("R3 reg0 ack", a, 1);
    m_stop();
    chk("R3 reg0", rf[0], 8'h5A);
  endtask

  task automatic t_read_burst();
    logic a;
    logic [7:0] v;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h02, a);
    m_start();
    send_byte(8'h91, a); chk("R7 R1 read address ack after repeated start", a, 1);
    recv_byte(1'b1, v); chk("R4 first read byte", v, 8'h11);
    recv_byte(1'b1, v); chk("R4 second read byte", v, 8'h22);
    recv_byte(1'b0, v); chk("R4 third read byte", v, 8'h33);
    tick(2);
    chk("R5 released after nack", sda_oe, 0);
    m_stop();
  endtask

  task automatic t_nack_hold();
    logic a;
    logic [7:0] v;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h03, a);
    m_start();
    send_byte(8'h91, a);
    recv_byte(1'b0, v); chk("R5 byte before nack", v, 8'h22);
    m_start();
    send_byte(8'h91, a); chk("R5 re-addressed after nack", a, 1);
    recv_byte(1'b0, v); chk("R5 pointer kept after nack", v, 8'h22);
    m_stop();
  endtask

  task automatic t_stop_ptr();
    logic a;
    logic [7:0] v;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h03, a);
    m_stop();
    m_start();
    send_byte(8'h91, a);
    recv_byte(1'b0, v); chk("R6 read after stop hits reg0", v, 8'h5A);
    m_stop();
    m_start();
    send_byte(8'h91, a);
    recv_byte(1'b1, v); chk("R6 poll reg0 again", v, 8'h5A);
    recv_byte(1'b0, v); chk("R6 follow-on byte", v, 8'hEE);
    m_stop();
    m_start();
    send_byte(8'h91, a);
    recv_byte(1'b0, v); chk("R6 stop cleared advanced pointer", v, 8'h5A);
    m_stop();
  endtask

  task automatic t_bad_addr();
    logic a;
    int   w0 = we_cnt;
    m_start();
    send_byte(8'h92, a); chk("R2 no ack for 0x49", a, 0);
    send_byte(8'h05, a); chk("R2 later byte ignored", a, 0);
    send_byte(8'h99, a); chk("R2 later byte ignored", a, 0);
    m_stop();
    m_start();
    send_byte(8'hA1, a); chk("R2 no ack for 0x50 read", a, 0);
    m_stop();
    chk("R2 no strobe", we_cnt - w0, 0);
    chk("R2 reg5 untouched", rf[5], 8'hEE);
  endtask

  task automatic t_bad_write();
    logic a;
    int   w0 = we_cnt;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h12, a);
    send_byte(8'h44, a); chk("R3 last valid reg ack", a, 1);
    send_byte(8'h55, a); chk("R8 out-of-range ack", a, 1);
    send_byte(8'h66, a); chk("R8 out-of-range ack", a, 1);
    m_stop();
    chk("R3 reg 0x12", rf[18], 8'h44);
    chk("R8 reg 0x13 untouched", rf[19], 8'hEE);
    chk("R8 strobe count across boundary", we_cnt - w0, 1);
    w0 = we_cnt;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h1F, a); chk("R8 pointer 0x1F ack", a, 1);
    send_byte(8'h77, a); chk("R8 data at 0x1F ack", a, 1);
    m_stop();
    chk("R8 no strobe at 0x1F", we_cnt - w0, 0);
    chk("R8 reg 0x1F untouched", rf[31], 8'hEE);
  endtask

  task automatic t_bad_read();
    logic a;
    logic [7:0] v;
    m_start();
    send_byte(8'h90, a);
    send_byte(8'h11, a);
    m_start();
    send_byte(8'h91, a);
    recv_byte(1'b1, v); chk("R4 reg 0x11", v, 8'hEE);
    recv_byte(1'b1, v); chk("R4 reg 0x12", v, 8'h44);
    recv_byte(1'b1, v); chk("R9 beyond range 0x13", v, 8'h00);
    recv_byte(1'b1, v); chk("R9 beyond range 0x14", v, 8'h00);
    recv_byte(1'b0, v); chk("R9 beyond range 0x15", v, 8'h00);
    m_stop();
  endtask

  initial begin
    t_reset();
    t_write_burst();
    t_read_burst();
    t_nack_hold();
    t_stop_ptr();
    t_bad_addr();
    t_bad_write();
    t_bad_read();
    chk("R10 enable raised while SCL high", oe_hi_chg, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule